// File: doc/BRIEF.md
# Cascadable Interrupt Controller

This block gathers 32 interrupt request lines into two processor interrupt outputs, one critical and one non-critical. Each line has its own settings for trigger type (level or edge), sense (active-high/rising or active-low/falling), enable, and routing. Level sources show their current pin state in the status register. Edge sources record an event that stays in the status register until software clears it by writing a one to that bit.

The block also computes a dispatch vector for the critical output. The vector is a programmable base plus sixteen times the index of the winning critical source. A register bit picks whether index 0 or index 31 has the highest priority. A cascade output goes high whenever any enabled source is pending. It can drive one input of a parent controller, so several units form a tree.

Software reaches the configuration through a plain synchronous register port. This port carries no data stream, so it has no valid/ready handshake. A write takes effect at the clock edge where `reg_wr` is sampled high. Read data appears on `reg_rdata` one clock after `reg_rd` is sampled high, and holds until the next read.

Top module: `icu_cascade_ctrl`

## Requirements
- R1: After reset, every configuration and status register reads zero, all three interrupt outputs are low, and `crit_vector` is zero.
- R2: A level-mode source's status bit equals (pin XOR invert bit) one clock after the pin is sampled. The invert register is at address 4; a 1 in that register means active-low.
- R3: A source is in edge mode when its bit in address 5 is 1. In edge mode, a change of (pin XOR invert) from inactive to active sets the status bit, and the bit stays set until it is cleared. A change of the invert bit alone creates no event.
- R4: Writing to address 0 clears each edge-mode status bit whose write-data bit is 1, and leaves bits written with 0 unchanged. A level-mode bit whose source is still active stays set after such a write.
- R5: Address 2 reads status AND enable, where the enable register is at address 1. Writes to address 2 have no effect. `crit_irq` is the OR of the masked bits whose route bit (address 3) is 1. `norm_irq` is the OR of the masked bits whose route bit is 0. A disabled source still shows in the raw status register at address 0.
- R6: When bit 0 of address 6 is 0, the lowest-numbered pending critical source wins. When it is 1, the highest-numbered one wins. The extremes, index 0 and index 31, obey the same rule.
- R7: While any critical source is pending, `crit_vector` equals the base register (address 7) plus 16 times the winner's index.
- R8: `crit_vector` is zero whenever no masked critical source is pending.
- R9: `cascade_irq` is high exactly when any masked source is pending, on either route.
- R10: Reads at addresses 1, 3, 4, 5 and 7 return the last value written. Address 6 returns only its bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_in | input | 32 | Interrupt request pins |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid one cycle after a read |
| crit_irq | output | 1 | Critical interrupt request |
| norm_irq | output | 1 | Non-critical interrupt request |
| crit_vector | output | 32 | Dispatch vector of the winning critical source |
| cascade_irq | output | 1 | Summary request for a parent controller |

## Verification
The bench targets an inverted edge source with a rising pin that must stay silent, followed by a falling pin that must fire. A design that ignored the sense bit would fire on the wrong transition. It also flips the invert bit while an edge source is idle; a design that compared against an already-inverted history would record a phantom event. It writes a one to clear a level source whose pin is still active; a design that treated every bit as sticky would drop that bit. Two pending critical sources, and then indices 0 and 31, are checked under both priority orders; a reversed or off-by-one encoder would report the wrong vector.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int unsigned REG_ADDR_W = 3;
  localparam int unsigned VEC_STRIDE_LOG2 = 4;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_STATUS = 3'd0,
    REG_ENABLE = 3'd1,
    REG_MASKED = 3'd2,
    REG_ROUTE  = 3'd3,
    REG_INVERT = 3'd4,
    REG_EDGE   = 3'd5,
    REG_ORDER  = 3'd6,
    REG_VBASE  = 3'd7
  } icu_reg_e;
endpackage

// File: rtl/icu_src_cell.sv
module icu_src_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic invert,
  input  logic edge_mode,
  input  logic clear,
  output logic status
);
  logic pin_q;
  logic act;
  logic prev_act;
  logic past_ok;

  // history holds the raw pin so that an invert change makes no event
  assign act      = pin ^ invert;
  assign prev_act = pin_q ^ invert;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q   <= 1'b0;
      status  <= 1'b0;
      past_ok <= 1'b0;
    end else begin
      pin_q   <= pin;
      past_ok <= 1'b1;
      if (edge_mode) status <= (status & ~clear) | (act & ~prev_act);
      else           status <= act;
    end
  end

  assert_level_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !edge_mode && $past(!edge_mode)) |-> (status == $past(act)));

  assert_edge_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && edge_mode && $past(edge_mode) && $past(status) && !$past(clear))
      |-> status);
endmodule

// File: rtl/icu_regs.sv
module icu_regs
  import icu_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic                  rd,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [N_SRC-1:0]      status,
  input  logic [N_SRC-1:0]      masked,
  output logic [N_SRC-1:0]      enable,
  output logic [N_SRC-1:0]      route,
  output logic [N_SRC-1:0]      invert,
  output logic [N_SRC-1:0]      edge_sel,
  output logic                  order_hi,
  output logic [DATA_W-1:0]     vbase,
  output logic [N_SRC-1:0]      clear,
  output logic [DATA_W-1:0]     rdata
);
  icu_reg_e sel;
  logic [DATA_W-1:0] rd_mux;

  assign sel   = icu_reg_e'(addr);
  assign clear = (wr && sel == REG_STATUS) ? wdata[N_SRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable   <= '0;
      route    <= '0;
      invert   <= '0;
      edge_sel <= '0;
      order_hi <= 1'b0;
      vbase    <= '0;
    end else if (wr) begin
      case (sel)
        REG_ENABLE: enable   <= wdata[N_SRC-1:0];
        REG_ROUTE:  route    <= wdata[N_SRC-1:0];
        REG_INVERT: invert   <= wdata[N_SRC-1:0];
        REG_EDGE:   edge_sel <= wdata[N_SRC-1:0];
        REG_ORDER:  order_hi <= wdata[0];
        REG_VBASE:  vbase    <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      REG_STATUS: rd_mux = DATA_W'(status);
      REG_ENABLE: rd_mux = DATA_W'(enable);
      REG_MASKED: rd_mux = DATA_W'(masked);
      REG_ROUTE:  rd_mux = DATA_W'(route);
      REG_INVERT: rd_mux = DATA_W'(invert);
      REG_EDGE:   rd_mux = DATA_W'(edge_sel);
      REG_ORDER:  rd_mux = DATA_W'(order_hi);
      REG_VBASE:  rd_mux = vbase;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end
endmodule

// File: rtl/icu_prio.sv
module icu_prio
  import icu_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  pend,
  input  logic              order_hi,
  input  logic [DATA_W-1:0] vbase,
  output logic              any,
  output logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] vector
);
  // later loop hits overwrite earlier ones, so the loop direction sets the winner
  always_comb begin
    idx = '0;
    if (order_hi) begin
      for (int i = 0; i < N_SRC; i++)
        if (pend[i]) idx = IDX_W'(i);
    end else begin
      for (int i = N_SRC - 1; i >= 0; i--)
        if (pend[i]) idx = IDX_W'(i);
    end
  end

  assign any    = |pend;
  assign vector = any ? vbase + (DATA_W'(idx) << VEC_STRIDE_LOG2) : '0;

  assert_vec_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !any |-> (vector == '0));

  assert_winner_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> pend[idx]);

  assert_low_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (any && !order_hi) |-> ((pend & ((N_SRC'(1) << idx) - N_SRC'(1))) == '0));

  assert_high_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (any && order_hi) |-> ((pend >> idx) == N_SRC'(1)));
endmodule

// File: rtl/icu_cascade_ctrl.sv
module icu_cascade_ctrl
  import icu_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_SRC-1:0]      src_in,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  output logic                  crit_irq,
  output logic                  norm_irq,
  output logic [DATA_W-1:0]     crit_vector,
  output logic                  cascade_irq
);
  localparam int unsigned IDX_W = $clog2(N_SRC);

  logic [N_SRC-1:0]  status, masked, enable, route, invert, edge_sel, clear;
  logic [N_SRC-1:0]  crit_set, norm_set;
  logic              order_hi, crit_any;
  logic [DATA_W-1:0] vbase;
  logic [IDX_W-1:0]  crit_idx;

  icu_regs #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .status(status), .masked(masked), .enable(enable),
    .route(route), .invert(invert), .edge_sel(edge_sel), .order_hi(order_hi),
    .vbase(vbase), .clear(clear), .rdata(reg_rdata)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    icu_src_cell u_cell (
      .clk(clk), .rst_n(rst_n), .pin(src_in[g]), .invert(invert[g]),
      .edge_mode(edge_sel[g]), .clear(clear[g]), .status(status[g])
    );
  end

  assign masked   = status & enable;
  assign crit_set = masked & route;
  assign norm_set = masked & ~route;

  icu_prio #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_prio (
    .clk(clk), .rst_n(rst_n), .pend(crit_set), .order_hi(order_hi),
    .vbase(vbase), .any(crit_any), .idx(crit_idx), .vector(crit_vector)
  );

  assign crit_irq    = crit_any;
  assign norm_irq    = |norm_set;
  assign cascade_irq = crit_irq | norm_irq;

  assert_route_split_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (crit_irq && !norm_irq) |-> ((masked & ~route) == '0));
endmodule

// File: tb/test_icu_cascade_ctrl.sv
module test_icu_cascade_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, crit_vector;
  logic        crit_irq, norm_irq, cascade_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  icu_cascade_ctrl i_icu_cascade_ctrl (
    .clk(clk), .rst_n(rst_n), .src_in(pins), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .crit_irq(crit_irq), .norm_irq(norm_irq), .crit_vector(crit_vector),
    .cascade_irq(cascade_irq)
  );

  typedef struct {
    bit          is_rd;
    logic [31:0] rd;
    logic        c, n, k;
    logic [31:0] v;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0, fails = 0;
  bit finished = 0;

  // monitor: compares one expected item per falling edge
  initial forever begin
    @(negedge clk);
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (e.is_rd) begin
        if (reg_rdata !== e.rd) begin
          fails++;
          $display("FAIL %s rdata actual=%h expected=%h", e.tag, reg_rdata, e.rd);
        end
      end else if ({crit_irq, norm_irq, cascade_irq} !== {e.c, e.n, e.k} ||
                   crit_vector !== e.v) begin
        fails++;
        $display("FAIL %s actual crit=%b norm=%b casc=%b vec=%h expected crit=%b norm=%b casc=%b vec=%h",
                 e.tag, crit_irq, norm_irq, cascade_irq, crit_vector, e.c, e.n, e.k, e.v);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [2:0] a, input logic [31:0] d, input string tag);
    exp_t e;
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); #1;
    e.is_rd = 1; e.rd = d; e.c = 0; e.n = 0; e.k = 0; e.v = '0; e.tag = tag;
    sb.push_back(e);
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic out_exp(input logic c, input logic n, input logic k,
                         input logic [31:0] v, input string tag);
    exp_t e;
    @(posedge clk); #1;
    e.is_rd = 0; e.rd = '0; e.c = c; e.n = n; e.k = k; e.v = v; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
  endtask

  task automatic pin(input int i, input logic val);
    @(negedge clk); pins[i] = val;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    out_exp(0, 0, 0, 32'h0, "R1 reset outputs");
    rd_exp(3'd0, 32'h0, "R1 reset status");
    rd_exp(3'd1, 32'h0, "R1 reset enable");
    wr(3'd7, 32'h100);
    rd_exp(3'd7, 32'h100, "R10 base readback");
    wr(3'd2, 32'hFFFF);
    rd_exp(3'd2, 32'h0, "R10 masked write ignored");
    wr(3'd1, 32'h0000_00E8);
    wr(3'd3, 32'h0000_0048);
    rd_exp(3'd3, 32'h48, "R10 route readback");
    pin(3, 1);
    out_exp(1, 0, 1, 32'h130, "R2 R7 level critical");
    rd_exp(3'd2, 32'h8, "R5 masked view");
    wr(3'd0, 32'h8);
    rd_exp(3'd0, 32'h8, "R4 level stays set after clear");
    pin(3, 0);
    out_exp(0, 0, 0, 32'h0, "R8 vector zero when idle");
    wr(3'd5, 32'h20);
    pin(5, 1);
    pin(5, 0);
    out_exp(0, 1, 1, 32'h0, "R3 R9 rising edge held");
    rd_exp(3'd0, 32'h20, "R3 status sticky");
    wr(3'd0, 32'h20);
    out_exp(0, 0, 0, 32'h0, "R4 edge cleared");
    wr(3'd5, 32'h60);
    wr(3'd4, 32'h40);
    out_exp(0, 0, 0, 32'h0, "R3 invert change no event");
    pin(6, 1);
    out_exp(0, 0, 0, 32'h0, "R3 rising ignored when inverted");
    pin(6, 0);
    out_exp(1, 0, 1, 32'h160, "R3 falling edge fires");
    pin(3, 1);
    out_exp(1, 0, 1, 32'h130, "R6 lowest index wins");
    wr(3'd6, 32'h1);
    out_exp(1, 0, 1, 32'h160, "R6 highest index wins");
    wr(3'd4, 32'hC0);
    out_exp(1, 1, 1, 32'h160, "R2 R5 inverted level non-critical");
    pin(3, 0);
    pin(7, 1);
    wr(3'd0, 32'h40);
    out_exp(0, 0, 0, 32'h0, "R4 R9 all cleared");
    pin(10, 1);
    out_exp(0, 0, 0, 32'h0, "R5 disabled source silent");
    rd_exp(3'd0, 32'h400, "R5 raw status shows disabled");
    rd_exp(3'd2, 32'h0, "R5 masked hides disabled");
    wr(3'd1, 32'h8000_00E9);
    wr(3'd3, 32'h8000_0049);
    pin(0, 1);
    pin(31, 1);
    out_exp(1, 0, 1, 32'h2F0, "R6 R7 index 31 wins");
    wr(3'd6, 32'hFFFF_FFFE);
    out_exp(1, 0, 1, 32'h100, "R6 R7 index 0 wins");
    rd_exp(3'd6, 32'h0, "R10 order keeps bit 0 only");
    wait (sb.size() == 0);
    @(negedge clk);
    summary();
  end
endmodule